// File: doc/BRIEF.md
# Flag Offset Byte Loader

This block keeps the two threshold offsets that a queue's almost-empty and almost-full flag logic compares against. Each offset is 16 bits wide and is held as two bytes, so the block owns four byte slots. Software or a host controller fills them one byte at a time over the ordinary write data bus. No address is presented. An internal load pointer picks the slot and moves to the next one after every qualified write. Once four bytes have been written, the pointer wraps back to the first slot.

The same four slots can be read back, one byte per qualified read, through a registered readback byte. The readback side has its own rotating pointer and follows the same slot order. Loading and readback can be interleaved freely, and each keeps its own place in the sequence. Reset sets both offsets to a default of 7, clears the readback byte and returns both pointers to the first slot. The 16-bit offsets drive the flag comparators directly. The comparators themselves and the queue storage belong to other blocks.

Top module: `ofs_offset_loader`

## Requirements
- R1: While `rst_n` is low, `empty_ofs` and `full_ofs` read 16'd7, `rb_data` reads 0, and both pointers return to slot 0, so the next load and the next readback both use slot 0.
- R2: On a rising `clk` edge with `wr_n` low and `acc_n` low, `wdata[7:0]` is stored into the slot named by the load pointer. The new value is visible on the offset outputs after that edge.
- R3: The slots follow a fixed order. Slot 0 is `empty_ofs[7:0]`, slot 1 is `empty_ofs[15:8]`, slot 2 is `full_ofs[7:0]` and slot 3 is `full_ofs[15:8]`. Successive loads visit them 0, 1, 2, 3.
- R4: After slot 3 has been loaded, the next qualified load writes slot 0 again.
- R5: An edge with `wr_n` high or `acc_n` high changes no offset byte and does not move the load pointer.
- R6: `wdata[8]` has no effect on any stored byte.
- R7: On a rising edge with `rd_n` low and `acc_n` low, `rb_data` takes the slot named by the readback pointer, and that pointer advances through the same order 0, 1, 2, 3, 0.
- R8: An edge with `rd_n` high or `acc_n` high leaves `rb_data` and the readback pointer unchanged.
- R9: The two pointers are independent. When a load and a readback qualify on the same edge, the readback returns the slot content from before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Write-side clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_n | input | 1 | Write enable, active low |
| rd_n | input | 1 | Read enable, active low |
| acc_n | input | 1 | Offset access strobe, active low; qualifies both loads and readbacks |
| wdata | input | 9 | Write data bus; only bits 7:0 are stored |
| empty_ofs | output | 16 | Almost-empty offset to the flag logic |
| full_ofs | output | 16 | Almost-full offset to the flag logic |
| rb_data | output | 8 | Registered readback byte |

## Verification
Every result is due exactly one rising edge after the stimulus that causes it, because the slot bytes and the readback byte are each a single register stage. A load's byte and a readback's byte both appear right after the qualifying edge. The bench applies inputs on the falling edge and lets one rising edge pass. It then compares all outputs on the following falling edge, against a model that performs the readback before the write at each edge. Reset takes effect asynchronously and is checked at the falling edge after it is applied.

// File: rtl/ofs_loader_pkg.sv
package ofs_loader_pkg;

    localparam int BYTE_W      = 8;
    localparam int DATA_W      = 9;
    localparam int NUM_SLOTS   = 4;
    localparam int PTR_W       = $clog2(NUM_SLOTS);
    localparam int OFS_W       = 2 * BYTE_W;
    localparam int DEFAULT_OFS = 7;

    typedef logic [PTR_W-1:0] slot_ptr_t;

    // Slot order is behaviour: the pointer visits these in ascending order.
    typedef enum slot_ptr_t {
        SLOT_EMPTY_LO = 2'd0,
        SLOT_EMPTY_HI = 2'd1,
        SLOT_FULL_LO  = 2'd2,
        SLOT_FULL_HI  = 2'd3
    } slot_e;

endpackage

// File: rtl/ofs_ring_ptr.sv
module ofs_ring_ptr #(
    parameter int SLOTS = 4,
    localparam int PW   = $clog2(SLOTS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step,
    output logic [PW-1:0] ptr
);

    typedef struct packed {
        logic [PW-1:0] ptr;
    } ptr_st_t;

    ptr_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (step) begin
            if (st_q.ptr == PW'(SLOTS - 1)) begin
                st_d.ptr = '0;
            end else begin
                st_d.ptr = st_q.ptr + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ptr = st_q.ptr;

endmodule

// File: rtl/ofs_byte_bank.sv
module ofs_byte_bank #(
    parameter int SLOTS       = 4,
    parameter int BYTE_W      = 8,
    parameter int DEFAULT_VAL = 7,
    localparam int PW         = $clog2(SLOTS),
    localparam int PAIR_W     = 2 * BYTE_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr,
    input  logic [PW-1:0]           wr_slot,
    input  logic [BYTE_W-1:0]       wr_byte,
    output logic [SLOTS*BYTE_W-1:0] bank
);

    localparam logic [PAIR_W-1:0] DEF_PAIR = PAIR_W'(DEFAULT_VAL);

    typedef struct packed {
        logic [SLOTS-1:0][BYTE_W-1:0] b;
    } bank_st_t;

    bank_st_t                     st_d, st_q;
    logic [SLOTS-1:0]             slot_hit;
    logic [SLOTS-1:0][BYTE_W-1:0] rst_val;

    // Even slots hold the low byte of a pair, odd slots the high byte.
    for (genvar i = 0; i < SLOTS; i++) begin : g_slot
        assign slot_hit[i] = wr && (wr_slot == PW'(i));
        assign rst_val[i]  = DEF_PAIR[(i % 2) * BYTE_W +: BYTE_W];
    end

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < SLOTS; i++) begin
            if (slot_hit[i]) begin
                st_d.b[i] = wr_byte;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.b <= rst_val;
        end else begin
            st_q <= st_d;
        end
    end

    assign bank = st_q.b;

endmodule

// File: rtl/ofs_readback.sv
module ofs_readback #(
    parameter int SLOTS  = 4,
    parameter int BYTE_W = 8,
    localparam int PW    = $clog2(SLOTS)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    rd,
    input  logic [PW-1:0]           sel,
    input  logic [SLOTS*BYTE_W-1:0] bank,
    output logic [BYTE_W-1:0]       rb
);

    typedef struct packed {
        logic [BYTE_W-1:0] rb;
    } rb_st_t;

    rb_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rd) begin
            st_d.rb = bank[sel * BYTE_W +: BYTE_W];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rb = st_q.rb;

endmodule

// File: rtl/ofs_offset_loader.sv
module ofs_offset_loader
    import ofs_loader_pkg::*;
#(
    parameter int BYTE_W   = ofs_loader_pkg::BYTE_W,
    parameter int DATA_W   = ofs_loader_pkg::DATA_W,
    parameter int DEF_OFS  = ofs_loader_pkg::DEFAULT_OFS,
    localparam int SLOTS   = ofs_loader_pkg::NUM_SLOTS,
    localparam int PW      = $clog2(SLOTS),
    localparam int OW      = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_n,
    input  logic              rd_n,
    input  logic              acc_n,
    input  logic [DATA_W-1:0] wdata,
    output logic [OW-1:0]     empty_ofs,
    output logic [OW-1:0]     full_ofs,
    output logic [BYTE_W-1:0] rb_data
);

    logic                    load_hit;
    logic                    read_hit;
    logic [PW-1:0]           ld_ptr;
    logic [PW-1:0]           rd_ptr;
    logic [SLOTS*BYTE_W-1:0] bank;
    logic                    unused_hi_bits;

    assign load_hit       = !wr_n && !acc_n;
    assign read_hit       = !rd_n && !acc_n;
    assign unused_hi_bits = ^wdata[DATA_W-1:BYTE_W];

    ofs_ring_ptr #(.SLOTS(SLOTS)) u_ld_ptr (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (load_hit),
        .ptr   (ld_ptr)
    );

    ofs_ring_ptr #(.SLOTS(SLOTS)) u_rd_ptr (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (read_hit),
        .ptr   (rd_ptr)
    );

    ofs_byte_bank #(
        .SLOTS       (SLOTS),
        .BYTE_W      (BYTE_W),
        .DEFAULT_VAL (DEF_OFS)
    ) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (load_hit),
        .wr_slot (ld_ptr),
        .wr_byte (wdata[BYTE_W-1:0]),
        .bank    (bank)
    );

    ofs_readback #(
        .SLOTS  (SLOTS),
        .BYTE_W (BYTE_W)
    ) u_rb (
        .clk   (clk),
        .rst_n (rst_n),
        .rd    (read_hit),
        .sel   (rd_ptr),
        .bank  (bank),
        .rb    (rb_data)
    );

    assign empty_ofs = {bank[int'(SLOT_EMPTY_HI) * BYTE_W +: BYTE_W],
                        bank[int'(SLOT_EMPTY_LO) * BYTE_W +: BYTE_W]};
    assign full_ofs  = {bank[int'(SLOT_FULL_HI) * BYTE_W +: BYTE_W],
                        bank[int'(SLOT_FULL_LO) * BYTE_W +: BYTE_W]};

endmodule

// File: rtl/ofs_offset_loader_chk.sv
module ofs_offset_loader_chk #(
    parameter int BYTE_W  = 8,
    parameter int DATA_W  = 9,
    parameter int DEF_OFS = 7,
    localparam int OW     = 2 * BYTE_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_n,
    input logic              rd_n,
    input logic              acc_n,
    input logic [DATA_W-1:0] wdata,
    input logic [OW-1:0]     empty_ofs,
    input logic [OW-1:0]     full_ofs,
    input logic [BYTE_W-1:0] rb_data,
    input logic [1:0]        ld_ptr,
    input logic [1:0]        rd_ptr
);

    function automatic logic [BYTE_W-1:0] slot_of(logic [2*OW-1:0] f, logic [1:0] i);
        return f[i * BYTE_W +: BYTE_W];
    endfunction

    logic [2*OW-1:0]   flat;
    logic [BYTE_W-1:0] cur_rd;
    logic              ld_q;
    logic              rd_q;

    assign flat   = {full_ofs, empty_ofs};
    assign cur_rd = slot_of(flat, rd_ptr);
    assign ld_q   = !wr_n && !acc_n;
    assign rd_q   = !rd_n && !acc_n;

    AST_RESET_DEFAULTS: assert property (@(posedge clk)
        !rst_n |=> (empty_ofs == OW'(DEF_OFS) && full_ofs == OW'(DEF_OFS) && rb_data == '0)); // R1

    AST_LOAD_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        ld_q |=> slot_of(flat, $past(ld_ptr)) == $past(wdata[BYTE_W-1:0])); // R2

    AST_LOAD_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        ld_q |=> ld_ptr == $past(ld_ptr) + 2'd1); // R4

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_q |=> ($stable(empty_ofs) && $stable(full_ofs) && $stable(ld_ptr))); // R5

    AST_RB_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        rd_q |=> (rb_data == $past(cur_rd) && rd_ptr == $past(rd_ptr) + 2'd1)); // R7

    AST_RB_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_q |=> ($stable(rb_data) && $stable(rd_ptr))); // R8

endmodule

bind ofs_offset_loader ofs_offset_loader_chk #(
    .BYTE_W  (BYTE_W),
    .DATA_W  (DATA_W),
    .DEF_OFS (DEF_OFS)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_n      (wr_n),
    .rd_n      (rd_n),
    .acc_n     (acc_n),
    .wdata     (wdata),
    .empty_ofs (empty_ofs),
    .full_ofs  (full_ofs),
    .rb_data   (rb_data),
    .ld_ptr    (ld_ptr),
    .rd_ptr    (rd_ptr)
);

// File: tb/ofs_offset_loader_test.sv
module ofs_offset_loader_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_n = 1'b1;
    logic        rd_n = 1'b1;
    logic        acc_n = 1'b1;
    logic [8:0]  wdata = '0;
    logic [15:0] empty_ofs;
    logic [15:0] full_ofs;
    logic [7:0]  rb_data;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [7:0] m_slot [4];
    int         m_lp;
    int         m_rp;
    logic [7:0] m_rb;

    always #2 clk = ~clk;

    ofs_offset_loader uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_n      (wr_n),
        .rd_n      (rd_n),
        .acc_n     (acc_n),
        .wdata     (wdata),
        .empty_ofs (empty_ofs),
        .full_ofs  (full_ofs),
        .rb_data   (rb_data)
    );

    function automatic logic [15:0] exp_empty();
        return {m_slot[1], m_slot[0]};
    endfunction

    function automatic logic [15:0] exp_full();
        return {m_slot[3], m_slot[2]};
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic model_reset();
        m_slot[0] = 8'd7; m_slot[1] = 8'd0; m_slot[2] = 8'd7; m_slot[3] = 8'd0;
        m_lp = 0; m_rp = 0; m_rb = 8'd0;
    endtask

    task automatic check_all(string req);
        chk({req, " empty_ofs"}, 32'(empty_ofs), 32'(exp_empty()));
        chk({req, " full_ofs"}, 32'(full_ofs), 32'(exp_full()));
        chk({req, " rb_data"}, 32'(rb_data), 32'(m_rb));
    endtask

    // Called at a falling edge; drives, waits one rising edge, checks at next falling edge.
    task automatic step(bit w, bit r, bit a, logic [8:0] d, string req);
        wr_n = w; rd_n = r; acc_n = a; wdata = d;
        @(posedge clk);
        if (!r && !a) begin
            m_rb = m_slot[m_rp];
            m_rp = (m_rp + 1) % 4;
        end
        if (!w && !a) begin
            m_slot[m_lp] = d[7:0];
            m_lp = (m_lp + 1) % 4;
        end
        @(negedge clk);
        check_all(req);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; wr_n = 1'b1; rd_n = 1'b1; acc_n = 1'b1;
        model_reset();
        @(posedge clk);
        @(negedge clk);
        check_all("R1");
        rst_n = 1'b1;
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        model_reset();
        @(negedge clk);
        do_reset();

        // R1: pointers start at slot 0 for both sides
        step(1'b0, 1'b0, 1'b0, 9'h011, "R1 ptr");
        do_reset();

        // R2/R3: four loads land in order
        step(1'b0, 1'b1, 1'b0, 9'h0A1, "R3 slot0");
        chk("R3 empty lo", 32'(empty_ofs[7:0]), 32'h0A1);
        step(1'b0, 1'b1, 1'b0, 9'h0B2, "R3 slot1");
        chk("R3 empty hi", 32'(empty_ofs[15:8]), 32'h0B2);
        step(1'b0, 1'b1, 1'b0, 9'h0C3, "R3 slot2");
        chk("R3 full lo", 32'(full_ofs[7:0]), 32'h0C3);
        step(1'b0, 1'b1, 1'b0, 9'h0D4, "R2 slot3");
        chk("R3 full hi", 32'(full_ofs[15:8]), 32'h0D4);

        // R4: fifth load wraps to slot 0
        step(1'b0, 1'b1, 1'b0, 9'h0E5, "R4 wrap");
        chk("R4 wrap byte", 32'(empty_ofs), 32'h0000B2E5);

        // R5: non-qualified edges change nothing, pointer holds
        step(1'b1, 1'b1, 1'b0, 9'h0FF, "R5 wr high");
        step(1'b0, 1'b1, 1'b1, 9'h0EE, "R5 acc high");
        step(1'b0, 1'b1, 1'b0, 9'h055, "R5 next slot");
        chk("R5 slot1 loaded", 32'(empty_ofs[15:8]), 32'h055);

        // R6: bit 8 dropped
        step(1'b0, 1'b1, 1'b0, 9'h1AA, "R6 bit8");
        chk("R6 stored byte", 32'(full_ofs[7:0]), 32'h0AA);

        // R7: readback five times, wraps
        for (int i = 0; i < 5; i++) step(1'b1, 1'b0, 1'b0, 9'h000, "R7 readback");
        chk("R7 wrap value", 32'(rb_data), 32'h0E5);

        // R8: readback holds when unqualified
        step(1'b1, 1'b0, 1'b1, 9'h000, "R8 acc high");
        step(1'b1, 1'b1, 1'b0, 9'h000, "R8 rd high");
        chk("R8 held", 32'(rb_data), 32'h0E5);

        // R9: simultaneous load and readback on the same slot returns old value
        do_reset();
        step(1'b0, 1'b0, 1'b0, 9'h03C, "R9 same edge");
        chk("R9 old byte", 32'(rb_data), 32'h007);
        chk("R9 new byte", 32'(empty_ofs[7:0]), 32'h03C);

        // Constrained random mix
        for (int i = 0; i < 3000; i++) begin
            if (($urandom % 250) == 0) begin
                do_reset();
            end else begin
                step(1'($urandom), 1'($urandom), 1'(($urandom % 3) == 0),
                     9'($urandom), "R2 R7 random");
            end
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule